// File: doc/BRIEF.md
# Trigger Line Routing Controller

This block holds the routing settings for a small set of backplane trigger lines. It steers each line to or from a pair of front-panel trigger connectors: one connector receives a trigger and the other sends one out. Each line has its own enable bit and direction bit in a 16-bit control word. When a line is enabled with the outward direction, its backplane level drives the output connector. When it is enabled with the inward direction, the input connector drives the backplane line. When it is disabled, the line is left alone whatever its direction bit holds.

The routing outputs come as drive enables with matching data, so the pad logic around the block can build the tristate buffers. When several lines are routed outward at the same time, line 0 has priority for the single output connector. The control bits are cleared only by the hard reset, which is asynchronous active-low and released on the clock. The soft reset input leaves every control bit unchanged. A write issued in a soft-reset cycle is discarded, so the bus cycle it belongs to is treated as aborted.

Top module: `trig_route_ctrl`

## Requirements
- R1: While the hard reset is asserted, `rd_data` reads 0, every `bp_drive_en` bit is 0 and `trig_out_en` is 0.
- R2: A write stores the enable of line i at bit 11+2i and its direction at bit 10+2i (line 1 at bits 13 and 12, line 0 at bits 11 and 10). The stored bits read back on `rd_data` after the clock edge that takes the write. All other bits read 0.
- R3: When the enable bit of a line is 0, that line's `bp_drive_en` is 0 and the line never drives the output connector, whatever its direction bit holds.
- R4: When a line is enabled with direction 0 (outward) and no lower-numbered line is routed outward, `trig_out_en` is 1 and `trig_out_data` follows that line's `bp_in` level.
- R5: When a line is enabled with direction 1 (inward), its `bp_drive_en` is 1 and its `bp_drive_data` follows `trig_in`.
- R6: When both lines are enabled outward, the output connector follows line 0.
- R7: `soft_rst` leaves all control bits unchanged, and a write presented in the same cycle as `soft_rst` is discarded.
- R8: When `trig_out_en` is 0, `trig_out_data` is 0. When a line's `bp_drive_en` is 0, its `bp_drive_data` is 0.
- R9: After the hard reset is released, writes presented at the first two rising clock edges are ignored. A write presented at the third edge is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high; keeps the control bits |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Current control word |
| bp_in | input | 2 | Sensed level of each backplane trigger line |
| trig_in | input | 1 | Level at the input connector |
| bp_drive_en | output | 2 | Drive enable per backplane line (inward routing) |
| bp_drive_data | output | 2 | Level to drive on each backplane line |
| trig_out_en | output | 1 | Drive enable for the output connector |
| trig_out_data | output | 1 | Level to drive on the output connector |

## Verification
A wrong enable or direction bit shows up on `rd_data` and on the routing outputs right after the clock edge that stored it. A wrong bit then misroutes every later input pattern until the next write, so a sweep of all sixteen control words against all eight input patterns exposes it. A priority or gating fault in the fabric is combinational and appears in the same cycle as the input change. A control word that changes across a soft reset is visible on the next read.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

  typedef enum logic {
    DIR_OUTWARD = 1'b0,
    DIR_INWARD  = 1'b1
  } route_dir_e;

  typedef struct packed {
    logic       en;
    route_dir_e dir;
  } line_ctl_t;

  // bit position of a line's enable inside the control word
  function automatic int en_pos(input int lsb, input int line);
    return lsb + 2 * line + 1;
  endfunction

  // bit position of a line's direction inside the control word
  function automatic int dir_pos(input int lsb, input int line);
    return lsb + 2 * line;
  endfunction

endpackage

// File: rtl/trg_rst_sync.sv
module trg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/trg_ctrl_reg.sv
module trg_ctrl_reg
  import trig_route_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int REG_W     = 16,
  parameter int CTRL_LSB  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic                       wr_en,
  input  logic [REG_W-1:0]           wr_data,
  output line_ctl_t [NUM_LINES-1:0]  ctl,
  output logic [REG_W-1:0]           rd_data
);

  localparam int CTRL_W = 2 * NUM_LINES;
  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'(((1 << CTRL_W) - 1) << CTRL_LSB);

  line_ctl_t [NUM_LINES-1:0] ctl_q;
  line_ctl_t [NUM_LINES-1:0] ctl_d;
  logic                      load_ce;
  logic                      unused_wr_bits;

  // a write coinciding with a soft reset belongs to an aborted cycle
  assign load_ce        = wr_en && !soft_rst;
  assign unused_wr_bits = ^(wr_data & ~CTRL_MASK);

  always_comb begin
    ctl_d = ctl_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      ctl_d[i].en  = wr_data[en_pos(CTRL_LSB, i)];
      ctl_d[i].dir = route_dir_e'(wr_data[dir_pos(CTRL_LSB, i)]);
    end
  end

  // only the hard reset path clears the control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (load_ce) ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      rd_data[en_pos(CTRL_LSB, i)]  = ctl_q[i].en;
      rd_data[dir_pos(CTRL_LSB, i)] = ctl_q[i].dir;
    end
  end

  assign ctl = ctl_q;

  assert_soft_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(ctl_q));

endmodule

// File: rtl/trg_route_fabric.sv
module trg_route_fabric
  import trig_route_pkg::*;
#(
  parameter int NUM_LINES = 2
) (
  input  line_ctl_t [NUM_LINES-1:0] ctl,
  input  logic [NUM_LINES-1:0]      bp_in,
  input  logic                      trig_in,
  output logic [NUM_LINES-1:0]      bp_drive_en,
  output logic [NUM_LINES-1:0]      bp_drive_data,
  output logic                      trig_out_en,
  output logic                      trig_out_data
);

  logic [NUM_LINES-1:0] outward_req;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign bp_drive_en[g]   = ctl[g].en && (ctl[g].dir == DIR_INWARD);
    assign bp_drive_data[g] = bp_drive_en[g] && trig_in;
    assign outward_req[g]   = ctl[g].en && (ctl[g].dir == DIR_OUTWARD);
  end

  // scan from the top so the lowest requesting line is assigned last
  always_comb begin
    trig_out_en   = 1'b0;
    trig_out_data = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (outward_req[i]) begin
        trig_out_en   = 1'b1;
        trig_out_data = bp_in[i];
      end
    end
  end

endmodule

// File: rtl/trig_route_ctrl.sv
module trig_route_ctrl
  import trig_route_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int REG_W       = 16,
  parameter int CTRL_LSB    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_hard_n,
  input  logic                 soft_rst,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_LINES-1:0] bp_in,
  input  logic                 trig_in,
  output logic [NUM_LINES-1:0] bp_drive_en,
  output logic [NUM_LINES-1:0] bp_drive_data,
  output logic                 trig_out_en,
  output logic                 trig_out_data
);

  localparam int CTRL_W = 2 * NUM_LINES;
  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'(((1 << CTRL_W) - 1) << CTRL_LSB);

  logic                      srst_n;
  line_ctl_t [NUM_LINES-1:0] ctl;

  trg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_hard_n),
    .srst_n (srst_n)
  );

  trg_ctrl_reg #(
    .NUM_LINES (NUM_LINES),
    .REG_W     (REG_W),
    .CTRL_LSB  (CTRL_LSB)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctl      (ctl),
    .rd_data  (rd_data)
  );

  trg_route_fabric #(.NUM_LINES(NUM_LINES)) u_fabric (
    .ctl           (ctl),
    .bp_in         (bp_in),
    .trig_in       (trig_in),
    .bp_drive_en   (bp_drive_en),
    .bp_drive_data (bp_drive_data),
    .trig_out_en   (trig_out_en),
    .trig_out_data (trig_out_data)
  );

  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !soft_rst) |=> (rd_data == ($past(wr_data) & CTRL_MASK)));

  assert_soft_keep_R7: assert property (@(posedge clk) disable iff (!srst_n)
    soft_rst |=> $stable(rd_data));

  assert_idle_out_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !trig_out_en |-> !trig_out_data);

  assert_line0_wins_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data[en_pos(CTRL_LSB, 0)] && !rd_data[dir_pos(CTRL_LSB, 0)])
      |-> (trig_out_en && (trig_out_data == bp_in[0])));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!srst_n)
      !rd_data[en_pos(CTRL_LSB, g)] |-> !bp_drive_en[g]);

    assert_inward_follow_R5: assert property (@(posedge clk) disable iff (!srst_n)
      bp_drive_en[g] |-> (bp_drive_data[g] == trig_in));

    assert_undriven_low_R8: assert property (@(posedge clk) disable iff (!srst_n)
      !bp_drive_en[g] |-> !bp_drive_data[g]);
  end

endmodule

// File: tb/trig_route_ctrl_test.sv
module trig_route_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_hard_n;
  logic        soft_rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  bp_in;
  logic        trig_in;
  logic [1:0]  bp_drive_en;
  logic [1:0]  bp_drive_data;
  logic        trig_out_en;
  logic        trig_out_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trig_route_ctrl uut (
    .clk           (clk),
    .rst_hard_n    (rst_hard_n),
    .soft_rst      (soft_rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .bp_in         (bp_in),
    .trig_in       (trig_in),
    .bp_drive_en   (bp_drive_en),
    .bp_drive_data (bp_drive_data),
    .trig_out_en   (trig_out_en),
    .trig_out_data (trig_out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [15:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_hard_n = 1'b0;
    soft_rst   = 1'b0;
    wr_en      = 1'b0;
    wr_data    = '0;
    bp_in      = '0;
    trig_in    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rd", 32'(rd_data), 0);
    chk("R1 drv", 32'(bp_drive_en), 0);
    chk("R1 out", 32'(trig_out_en), 0);
    rst_hard_n = 1'b1;
    repeat (3) @(negedge clk);

    // bits outside the trigger field read as zero
    do_write(16'hFFFF);
    chk("R2 all ones", 32'(rd_data), 32'h3C00);
    do_write(16'hC3FF);
    chk("R2 outside", 32'(rd_data), 0);

    // full sweep: four control bits against three routing inputs
    for (int c = 0; c < 16; c++) begin
      do_write(16'(c << 10));
      chk("R2 readback", 32'(rd_data), 32'(c << 10));
      for (int s = 0; s < 8; s++) begin
        logic [1:0] e_den, e_dd;
        logic       e_oen, e_od, both_out;
        bp_in   = s[1:0];
        trig_in = s[2];
        #1;
        for (int i = 0; i < 2; i++) begin
          e_den[i] = c[2*i+1] & c[2*i];
          e_dd[i]  = e_den[i] & s[2];
        end
        both_out = (c[1] & ~c[0]) & (c[3] & ~c[2]);
        if (c[1] & ~c[0])      begin e_oen = 1'b1; e_od = s[0]; end
        else if (c[3] & ~c[2]) begin e_oen = 1'b1; e_od = s[1]; end
        else                   begin e_oen = 1'b0; e_od = 1'b0; end
        for (int i = 0; i < 2; i++) begin
          if (!c[2*i+1]) chk("R3 line off", 32'(bp_drive_en[i]), 0);
          else           chk("R5 drive en", 32'(bp_drive_en[i]), 32'(e_den[i]));
          if (e_den[i])  chk("R5 drive data", 32'(bp_drive_data[i]), 32'(e_dd[i]));
          else           chk("R8 drive data", 32'(bp_drive_data[i]), 0);
        end
        chk("R4 out en", 32'(trig_out_en), 32'(e_oen));
        if (both_out)    chk("R6 priority", 32'(trig_out_data), 32'(e_od));
        else if (e_oen)  chk("R4 out data", 32'(trig_out_data), 32'(e_od));
        else             chk("R8 out data", 32'(trig_out_data), 0);
        @(negedge clk);
      end
    end

    // soft reset keeps the word and aborts a concurrent write
    do_write(16'h2C00);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R7 hold", 32'(rd_data), 32'h2C00);
    bp_in = 2'b10; trig_in = 1'b1; #1;
    chk("R7 routing", 32'({trig_out_en, trig_out_data, bp_drive_en}), 32'b1101);
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    chk("R7 write dropped", 32'(rd_data), 32'h2C00);

    // hard reset clears, writes in first two edges after release ignored
    rst_hard_n = 1'b0;
    #1;
    chk("R1 clear", 32'(rd_data), 0);
    chk("R1 drive", 32'(bp_drive_en), 0);
    @(negedge clk);
    rst_hard_n = 1'b1;
    wr_en = 1'b1; wr_data = 16'h0800;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 early write", 32'(rd_data), 0);
    do_write(16'h0800);
    chk("R9 third edge", 32'(rd_data), 32'h0800);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule